// File: doc/BRIEF.md
# Lane-Partitioned Vector Register and Add Unit

This block holds a bank of thirty-two 128-bit vector registers and executes four kinds of vector command on them. The first is an element-wise add, where one 128-bit adder is cut into independent lanes of 32, 16 or 8 bits. The second broadcasts a 32-bit scalar into every word of a register. The last two are a four-word load and a four-word store. Both go through a narrow 32-bit memory request port that uses a valid/ready handshake.

A command is offered with `cmd_valid` and is taken on any clock edge where `busy` is low. An add or a broadcast finishes in the cycle it is taken. A load or a store first works out a byte address, which is the scalar operand plus the sign-extended 16-bit offset. It then walks the four words of the register from the lowest upward, one memory handshake per word. It holds `busy` high until the last word has been exchanged. A load commits all 128 bits to its destination register in a single write. If the address is not word aligned, the command raises `err` for one cycle and makes no memory access at all.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset every register holds zero, and `busy`, `err` and `mem_req_valid` are low.
- R2: A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low. `cmd_op` encodes 0 = add, 1 = broadcast, 2 = load, 3 = store. The result of an add or a broadcast can be read by the command accepted on the very next edge.
- R3: An add with `cmd_lane` = 0 writes vd word k = (vs word k + vt word k) mod 2^32. Word k is bits [32k+31:32k]. No carry passes between words.
- R4: An add with `cmd_lane` = 1 works on eight 16-bit lanes (lane k is bits [16k+15:16k]). Each lane wraps modulo 2^16 and no carry passes into the next lane.
- R5: An add with `cmd_lane` = 2 works on sixteen 8-bit lanes, each wrapping modulo 2^8. `cmd_lane` = 3 behaves like word lanes.
- R6: A broadcast writes `cmd_gpr` into all four words of register vd.
- R7: A load or store uses the base address `cmd_gpr` + sign-extended `cmd_imm`. It issues exactly four requests in order, to base, base+4, base+8 and base+12, which carry words 0, 1, 2 and 3 of the register.
- R8: A store sends register vd with `mem_req_write` = 1 and puts word k on `mem_req_wdata` for request k. A request that is not yet accepted keeps its address and direction until `mem_req_ready` is high.
- R9: A load has `mem_req_write` = 0 and samples `mem_rdata` on each handshake edge. After the fourth handshake, register vd holds the four received words with the first one in word 0.
- R10: `busy` is high from the edge that accepts a load or store through the edge of its fourth handshake, and low after that. Commands offered while `busy` is high are ignored and change no register.
- R11: If the base address of a load or store has either of its two low bits set, `err` is high for exactly the one cycle after acceptance. In that case no request is issued, `busy` stays low and no register changes.
- R12: An add whose destination is also a source reads the value the register held before that add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command code (add, broadcast, load, store) |
| cmd_lane | input | 2 | Lane width select for add |
| cmd_vd | input | 5 | Destination register, or source register for store |
| cmd_vs | input | 5 | First add source register |
| cmd_vt | input | 5 | Second add source register |
| cmd_gpr | input | 32 | Scalar operand: broadcast value or address base |
| cmd_imm | input | 16 | Signed address offset |
| busy | output | 1 | Memory transfer in progress; commands not accepted |
| err | output | 1 | One-cycle misalignment flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data word |
| mem_req_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Read data, valid on a read handshake |

## Verification
The hardest case to reach from the ports is a command offered while a store is still draining. On that edge the sequencer owns the bank, and a wrongly accepted command would quietly change a register. The bench raises a broadcast in the first cycle of a store transfer, and the memory model's `mem_req_ready` is randomly stalled so that the transfer stays open. It then reads the broadcast's target back through a later store to show that the register is untouched. Carry isolation at lane boundaries is pushed with operands made entirely of ones and with all-top-bit patterns in every lane mode. Randomly chosen lane codes, including the code 3 alias, are mixed with loads, broadcasts and readbacks at random offsets.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_FILL  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STORE = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        LN_WORD = 2'd0,
        LN_HALF = 2'd1,
        LN_BYTE = 2'd2,
        LN_WIDE = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_STORE = 2'd2
    } sq_e;

endpackage

// File: rtl/vlu_regfile.sv
module vlu_regfile #(
    parameter int NREG = 32,
    parameter int VLEN = 128,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [VLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [IDX_W-1:0] rc_idx,
    output logic [VLEN-1:0]  ra,
    output logic [VLEN-1:0]  rb,
    output logic [VLEN-1:0]  rc
);

    logic [VLEN-1:0] bank [NREG];

    for (genvar e = 0; e < NREG; e++) begin : g_ent
        logic [VLEN-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (widx == IDX_W'(e))) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign bank[e] = ent_q;
    end

    // reads see the registered contents: a write lands only at the edge
    assign ra = bank[ra_idx];
    assign rb = bank[rb_idx];
    assign rc = bank[rc_idx];

endmodule

// File: rtl/vlu_lane_adder.sv
module vlu_lane_adder #(
    parameter int VLEN = 128,
    parameter int GRAN = 8,
    localparam int NSEG = VLEN / GRAN
) (
    input  logic [VLEN-1:0] a,
    input  logic [VLEN-1:0] b,
    input  logic [1:0]      lane,
    output logic [VLEN-1:0] sum
);
    import vlu_pkg::*;

    logic [NSEG-1:0] cy;
    logic            mode_byte;
    logic            mode_half;

    assign mode_byte = (lane == LN_BYTE);
    assign mode_half = (lane == LN_HALF);
    assign cy[0]     = 1'b0;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam logic HALF_EDGE = ((g % 2) == 0);
        localparam logic WORD_EDGE = ((g % 4) == 0);
        logic cut;
        logic cin;

        // carry is cut at every lane boundary selected by the mode
        assign cut = mode_byte || (mode_half && HALF_EDGE) || WORD_EDGE;
        assign cin = cut ? 1'b0 : cy[g];

        if (g == NSEG - 1) begin : g_top
            assign sum[g*GRAN +: GRAN] = a[g*GRAN +: GRAN] + b[g*GRAN +: GRAN]
                                       + {{(GRAN-1){1'b0}}, cin};
        end else begin : g_mid
            assign {cy[g+1], sum[g*GRAN +: GRAN]} =
                {1'b0, a[g*GRAN +: GRAN]} + {1'b0, b[g*GRAN +: GRAN]}
                + {{GRAN{1'b0}}, cin};
        end
    end

endmodule

// File: rtl/vlu_mem_seq.sv
module vlu_mem_seq #(
    parameter int NREG = 32,
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int NBEAT = VLEN / XLEN,
    localparam int BW    = $clog2(NBEAT),
    localparam int SH    = $clog2(XLEN / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_load,
    input  logic [XLEN-1:0]  base_in,
    input  logic [IDX_W-1:0] vd_in,
    input  logic [VLEN-1:0]  store_data,
    output logic             busy,
    output logic             req_valid,
    output logic             req_write,
    output logic [XLEN-1:0]  req_addr,
    output logic [XLEN-1:0]  req_wdata,
    input  logic             req_ready,
    input  logic [XLEN-1:0]  rdata,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [VLEN-1:0]  wb_data
);
    import vlu_pkg::*;

    typedef struct packed {
        sq_e              st;
        logic [BW-1:0]    beat;
        logic [XLEN-1:0]  base;
        logic [IDX_W-1:0] vd;
        logic [VLEN-1:0]  data;
    } seq_t;

    seq_t sq_d, sq_q;
    logic hs;
    logic last;

    always_comb begin
        sq_d  = sq_q;
        wb_en = 1'b0;
        hs    = (sq_q.st != SQ_IDLE) && req_ready;
        last  = (sq_q.beat == BW'(NBEAT - 1));
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    sq_d.st   = is_load ? SQ_LOAD : SQ_STORE;
                    sq_d.beat = '0;
                    sq_d.base = base_in;
                    sq_d.vd   = vd_in;
                    sq_d.data = is_load ? '0 : store_data;
                end
            end
            SQ_LOAD: begin
                if (hs) begin
                    sq_d.data[sq_q.beat*XLEN +: XLEN] = rdata;
                    if (last) begin
                        wb_en     = 1'b1;
                        sq_d.st   = SQ_IDLE;
                        sq_d.beat = '0;
                    end else begin
                        sq_d.beat = sq_q.beat + BW'(1);
                    end
                end
            end
            SQ_STORE: begin
                if (hs) begin
                    if (last) begin
                        sq_d.st   = SQ_IDLE;
                        sq_d.beat = '0;
                    end else begin
                        sq_d.beat = sq_q.beat + BW'(1);
                    end
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy      = (sq_q.st != SQ_IDLE);
    assign req_valid = busy;
    assign req_write = (sq_q.st == SQ_STORE);
    assign req_addr  = sq_q.base + (XLEN'(sq_q.beat) << SH);
    assign req_wdata = sq_q.data[sq_q.beat*XLEN +: XLEN];
    assign wb_idx    = sq_q.vd;
    assign wb_data   = sq_d.data;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write));

    // R7
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[SH-1:0] == '0));

    // R10
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(req_valid && req_ready));

    // R9
    load_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> req_valid && req_ready && !req_write);

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit #(
    parameter int NREG  = 32,
    parameter int VLEN  = 128,
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int NWORD = VLEN / XLEN,
    localparam int SH    = $clog2(XLEN / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [1:0]       cmd_lane,
    input  logic [IDX_W-1:0] cmd_vd,
    input  logic [IDX_W-1:0] cmd_vs,
    input  logic [IDX_W-1:0] cmd_vt,
    input  logic [XLEN-1:0]  cmd_gpr,
    input  logic [IMM_W-1:0] cmd_imm,
    output logic             busy,
    output logic             err,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [XLEN-1:0]  mem_req_addr,
    output logic [XLEN-1:0]  mem_req_wdata,
    input  logic             mem_req_ready,
    input  logic [XLEN-1:0]  mem_rdata
);
    import vlu_pkg::*;

    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;

    logic             fire;
    logic             is_mem;
    logic             misal;
    logic [XLEN-1:0]  ea;
    logic             seq_start;
    logic             ex_we;
    logic [VLEN-1:0]  ex_data;
    logic [VLEN-1:0]  src_a, src_b, src_c;
    logic [VLEN-1:0]  add_sum;
    logic             rf_we;
    logic [IDX_W-1:0] rf_idx;
    logic [VLEN-1:0]  rf_data;
    logic             wb_en;
    logic [IDX_W-1:0] wb_idx;
    logic [VLEN-1:0]  wb_data;

    always_comb begin
        top_d     = top_q;
        fire      = cmd_valid && !busy;
        is_mem    = (cmd_op == OP_LOAD) || (cmd_op == OP_STORE);
        ea        = cmd_gpr + {{(XLEN-IMM_W){cmd_imm[IMM_W-1]}}, cmd_imm};
        misal     = (ea[SH-1:0] != '0);
        seq_start = fire && is_mem && !misal;
        ex_we     = fire && !is_mem;
        ex_data   = (cmd_op == OP_FILL) ? {NWORD{cmd_gpr}} : add_sum;
        top_d.err = fire && is_mem && misal;
        rf_we     = ex_we || wb_en;
        rf_idx    = wb_en ? wb_idx  : cmd_vd;
        rf_data   = wb_en ? wb_data : ex_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign err = top_q.err;

    vlu_regfile #(.NREG(NREG), .VLEN(VLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .widx   (rf_idx),
        .wdata  (rf_data),
        .ra_idx (cmd_vs),
        .rb_idx (cmd_vt),
        .rc_idx (cmd_vd),
        .ra     (src_a),
        .rb     (src_b),
        .rc     (src_c)
    );

    vlu_lane_adder #(.VLEN(VLEN), .GRAN(8)) u_add (
        .a    (src_a),
        .b    (src_b),
        .lane (cmd_lane),
        .sum  (add_sum)
    );

    vlu_mem_seq #(.NREG(NREG), .VLEN(VLEN), .XLEN(XLEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .is_load    (cmd_op == OP_LOAD),
        .base_in    (ea),
        .vd_in      (cmd_vd),
        .store_data (src_c),
        .busy       (busy),
        .req_valid  (mem_req_valid),
        .req_write  (mem_req_write),
        .req_addr   (mem_req_addr),
        .req_wdata  (mem_req_wdata),
        .req_ready  (mem_req_ready),
        .rdata      (mem_rdata),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data)
    );

    // R11
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && is_mem && misal |=> err && !busy && !mem_req_valid);

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err || $past(cmd_valid));

    // R10
    no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_we && wb_en));

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !mem_req_valid);

endmodule

// File: tb/vec_lane_unit_bench.sv
module vec_lane_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = '0;
    logic [1:0]   cmd_lane = '0;
    logic [4:0]   cmd_vd = '0, cmd_vs = '0, cmd_vt = '0;
    logic [31:0]  cmd_gpr = '0;
    logic [15:0]  cmd_imm = '0;
    logic         busy, err;
    logic         mem_req_valid, mem_req_write;
    logic [31:0]  mem_req_addr, mem_req_wdata;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [127:0] mdl [32];

    vec_lane_unit u_vec_lane_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lane(cmd_lane), .cmd_vd(cmd_vd), .cmd_vs(cmd_vs), .cmd_vt(cmd_vt),
        .cmd_gpr(cmd_gpr), .cmd_imm(cmd_imm), .busy(busy), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog: actual cycles %0d expected < %0d", cyc, WD_LIMIT);
            report();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] lane_add(input logic [127:0] a, input logic [127:0] b, input logic [1:0] ln);
        int w;
        logic [63:0] mask, x, y;
        logic [127:0] r;
        w = (ln == 2'd1) ? 16 : (ln == 2'd2) ? 8 : 32;
        mask = (64'd1 << w) - 64'd1;
        r = '0;
        for (int i = 0; i < 128 / w; i++) begin
            x = 64'(a >> (i * w)) & mask;
            y = 64'(b >> (i * w)) & mask;
            r = r | (128'((x + y) & mask) << (i * w));
        end
        return r;
    endfunction

    function automatic logic [31:0] eff_addr(input logic [31:0] g, input logic [15:0] imm);
        return g + {{16{imm[15]}}, imm};
    endfunction

    task automatic send(input logic [1:0] op, input logic [1:0] ln, input logic [4:0] vd,
                        input logic [4:0] vs, input logic [4:0] vt,
                        input logic [31:0] g, input logic [15:0] imm);
        @(negedge clk);
        cmd_op = op; cmd_lane = ln; cmd_vd = vd; cmd_vs = vs; cmd_vt = vt;
        cmd_gpr = g; cmd_imm = imm; cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    // Drives the memory side of one transfer and checks each request (R7, R8, R10).
    task automatic run_mem(input bit is_store, input logic [31:0] base, input logic [127:0] data,
                           input bit inject, input string req);
        int beat = 0;
        bit first = 1'b1;
        while (beat < 4) begin
            @(negedge clk);
            if (first) begin
                chk(busy === 1'b1, "R10 busy during transfer", 128'(busy), 128'(1));
                first = 1'b0;
                if (inject) begin
                    // offered while busy: must be ignored (R10)
                    cmd_op = 2'd1; cmd_vd = 5'd9; cmd_gpr = 32'hDEADBEEF; cmd_valid = 1'b1;
                end
            end else begin
                cmd_valid = 1'b0;
            end
            mem_req_ready = (($urandom % 3) != 0);
            if (mem_req_valid === 1'b1) begin
                chk(mem_req_addr === base + 32'(4 * beat), {req, " R7 address"},
                    128'(mem_req_addr), 128'(base + 32'(4 * beat)));
                chk(mem_req_write === is_store, {req, " R8 direction"},
                    128'(mem_req_write), 128'(is_store));
                if (is_store) begin
                    chk(mem_req_wdata === data[32*beat +: 32], {req, " R8 store word"},
                        128'(mem_req_wdata), 128'(data[32*beat +: 32]));
                end
                mem_rdata = data[32*beat +: 32];
                if (mem_req_ready) beat++;
            end
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        cmd_valid = 1'b0;
        chk(busy === 1'b0, "R10 busy released", 128'(busy), 128'(0));
        chk(mem_req_valid === 1'b0, "R7 four requests only", 128'(mem_req_valid), 128'(0));
    endtask

    task automatic readback(input logic [4:0] r, input string req);
        logic [31:0] g;
        logic [15:0] imm;
        g   = 32'h1000_0000 + 32'(r) * 32'd64;
        imm = 16'(($urandom % 256) * 4);
        send(2'd3, 2'd0, r, 5'd0, 5'd0, g, imm);
        run_mem(1'b1, eff_addr(g, imm), mdl[r], 1'b0, req);
    endtask

    task automatic do_fill(input logic [4:0] vd, input logic [31:0] v);
        send(2'd1, 2'd0, vd, 5'd0, 5'd0, v, 16'd0);
        mdl[vd] = {4{v}};
    endtask

    task automatic do_add(input logic [4:0] vd, input logic [4:0] vs, input logic [4:0] vt, input logic [1:0] ln);
        logic [127:0] e;
        e = lane_add(mdl[vs], mdl[vt], ln);
        send(2'd0, ln, vd, vs, vt, 32'd0, 16'd0);
        mdl[vd] = e;
    endtask

    task automatic do_load(input logic [4:0] vd, input logic [31:0] g, input logic [15:0] imm);
        logic [127:0] d;
        d = {$urandom, $urandom, $urandom, $urandom};
        send(2'd2, 2'd0, vd, 5'd0, 5'd0, g, imm);
        run_mem(1'b0, eff_addr(g, imm), d, 1'b0, "R9 load");
        mdl[vd] = d;
    endtask

    task automatic misaligned(input logic [1:0] op, input logic [4:0] vd, input logic [31:0] g, input logic [15:0] imm);
        send(op, 2'd0, vd, 5'd0, 5'd0, g, imm);
        @(negedge clk);
        chk(err === 1'b1, "R11 err raised", 128'(err), 128'(1));
        chk(busy === 1'b0, "R11 no busy", 128'(busy), 128'(0));
        chk(mem_req_valid === 1'b0, "R11 no request", 128'(mem_req_valid), 128'(0));
        @(negedge clk);
        chk(err === 1'b0, "R11 err one cycle", 128'(err), 128'(0));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in every register
        chk(busy === 1'b0, "R1 busy after reset", 128'(busy), 128'(0));
        chk(err === 1'b0, "R1 err after reset", 128'(err), 128'(0));
        chk(mem_req_valid === 1'b0, "R1 req after reset", 128'(mem_req_valid), 128'(0));
        for (int r = 0; r < 32; r++) readback(5'(r), "R1 reset contents");

        // R6 broadcast, R2 result visible on the next command
        do_fill(5'd1, 32'hFFFF_FFFF);
        readback(5'd1, "R6 broadcast ones");
        do_fill(5'd2, 32'h0000_0001);
        // R3 word lanes: every word wraps to zero, no carry into neighbour
        do_add(5'd3, 5'd1, 5'd2, 2'd0);
        readback(5'd3, "R3 word wrap");
        // R4 half lanes: low half wraps, high half stays all ones
        do_add(5'd4, 5'd1, 5'd2, 2'd1);
        readback(5'd4, "R4 half carry cut");
        // R5 byte lanes
        do_add(5'd5, 5'd1, 5'd2, 2'd2);
        readback(5'd5, "R5 byte carry cut");
        do_fill(5'd6, 32'h8080_8080);
        for (int ln = 0; ln < 4; ln++) begin
            do_add(5'd7, 5'd6, 5'd6, 2'(ln));
            readback(5'd7, "R5 top-bit lanes, code 3 as word");
        end
        // R12: destination equals both sources
        do_add(5'd6, 5'd6, 5'd6, 2'd0);
        readback(5'd6, "R12 old value read");
        // R2: add directly after a broadcast reads the new value
        do_fill(5'd10, 32'h1234_5678);
        do_add(5'd11, 5'd10, 5'd10, 2'd1);
        readback(5'd11, "R2 back-to-back");

        // R7 negative offset and address wrap, R9 load
        do_load(5'd12, 32'h0000_0100, 16'hFFF0);
        readback(5'd12, "R9 load contents");
        do_load(5'd13, 32'h0000_0000, 16'hFFF0);
        readback(5'd13, "R9 load at wrapped address");

        // R11 misaligned load and store leave registers alone
        do_fill(5'd8, 32'hA5A5_5A5A);
        misaligned(2'd2, 5'd8, 32'h0000_0102, 16'd0);
        misaligned(2'd3, 5'd8, 32'h0000_0100, 16'h0001);
        readback(5'd8, "R11 register unchanged");

        // R10 command offered while a store is in flight is ignored
        do_fill(5'd9, 32'h0BAD_F00D);
        send(2'd3, 2'd0, 5'd9, 5'd0, 5'd0, 32'h0000_2000, 16'd0);
        run_mem(1'b1, 32'h0000_2000, mdl[9], 1'b1, "R10 store with offered command");
        readback(5'd9, "R10 ignored while busy");

        // random mix
        for (int it = 0; it < 200; it++) begin
            int sel;
            sel = $urandom % 4;
            case (sel)
                0: do_add(5'($urandom), 5'($urandom), 5'($urandom), 2'($urandom));
                1: do_fill(5'($urandom), $urandom);
                2: do_load(5'($urandom), $urandom & 32'hFFFF_FFFC, 16'($urandom) & 16'hFFFC);
                default: readback(5'($urandom), "R3 random readback");
            endcase
        end
        for (int r = 0; r < 32; r++) readback(5'(r), "R5 final contents");

        report();
        $finish;
    end

endmodule